// File: doc/BRIEF.md
# MDIO Management Interface Master

This block runs single register transactions on a two-wire PHY management bus. It derives a management clock (MDC) from the system clock with a programmable half-period divider, and it drives or listens on a shared bidirectional data line. The data line is modelled as three signals: an output value, an output enable and an input. A caller offers one request at a time, with a read/write select, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. When the frame has finished, the block returns a one-cycle done pulse, the read value and an error flag.

Every frame opens with a full all-ones preamble, sent whether the PHY needs it or not. It then carries start, opcode and the two address fields. On reads, the block releases the line and checks the turnaround bit, which a PHY that is present pulls low. If that bit is high, no PHY answered. The block then clocks a long run of idle cycles to bring the bus back to a known state, and reports an error with a zero data word. The input passes through a two-flop synchronizer, and the sample point sits at the last system clock of the MDC high half so that the synchronizer delay is absorbed inside the bit slot.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, busy, done, err, mdc, mdio_oe and rd_data are all 0.
- R2: MDC is low while the block is idle. During a frame, each MDC low half and each high half lasts exactly HALF_DIV system clock cycles (HALF_DIV >= 2). Each bit slot is one low half followed by one high half.
- R3: Every frame begins with 32 MDC cycles in which MDIO is driven to 1.
- R4: After the preamble come 14 driven bits, in this order: start 0,1; opcode 1,0 for a read or 0,1 for a write; PHY address bits 4..0; register address bits 4..0. A bit is placed at the start of its slot and held through the rising edge.
- R5: On a write, the header is followed by turnaround 1,0 and then 16 data bits sent MSB first. MDIO is then released for one final MDC cycle. The frame is 65 MDC cycles long, of which 64 are driven. When it completes, err is 0 and rd_data keeps its previous value.
- R6: On a read, MDIO is released (mdio_oe = 0) from the cycle after the register address until the frame ends. The turnaround bit is sampled in the high half of the first released cycle.
- R7: On a read where the turnaround sample is 0, the 16 cycles that follow are sampled in their high halves and assembled MSB first. Two more released cycles follow, for 65 in total. At done, rd_data holds the value and err is 0.
- R8: On a read where the turnaround sample is 1, 32 more released MDC cycles follow, for 79 in total. The frame ends with err = 1 and rd_data = 0. err is never set by a write.
- R9: busy rises on the clock edge that accepts a request and falls on the edge that raises done. done is a single-cycle pulse. It rises 2·HALF_DIV·N clock edges after the accepting edge, where N is the frame's MDC cycle count (65 or 79).
- R10: A request that is raised while busy is high is ignored. The running frame is unchanged, and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, accepted only while idle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last completed read saw no PHY |
| rd_data | output | 16 | Data of the last completed read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The frame is driven with directed extremes: all-zero and all-ones addresses and data, so that a stuck or misordered bit in any field shows up. Those cases are mixed with random reads and writes in which about a quarter of the reads target an absent PHY, which separates the answered-read path from the flush-and-error path by both MDC cycle count and done latency. A PHY model in the bench decodes the driven header independently and answers only a read to its own address, so that opcode or address encoding errors turn into wrong error flags. Requests raised in the middle of a frame check that the frame in flight is left alone and that no extra frame follows.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W       = 5;
  localparam int REG_W       = 5;
  localparam int DATA_W      = 16;
  localparam int PRE_SLOTS   = 32;
  localparam int FLUSH_SLOTS = 32;
  localparam int HDR_W       = 4 + PHY_W + REG_W;
  localparam int IDX_W       = 6;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_HDR, PH_TA, PH_WDAT, PH_RDAT, PH_TAIL, PH_FLUSH
  } phase_t;

  // start(01), opcode, phy, reg packed for MSB-first shifting
  function automatic logic [HDR_W-1:0] make_header(input logic rd,
                                                   input logic [PHY_W-1:0] phy,
                                                   input logic [REG_W-1:0] rg);
    return {2'b01, (rd ? 2'b10 : 2'b01), phy, rg};
  endfunction

  function automatic int unsigned ta_slots(input logic rd);
    return rd ? 1 : 2;
  endfunction

  function automatic int unsigned tail_slots(input logic rd);
    return rd ? 2 : 1;
  endfunction
endpackage

// File: rtl/mdc_phase_gen.sv
module mdc_phase_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic half_end,
  output logic slot_end
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      hi  <= ~hi;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign half_end = run && (cnt == LAST);
  assign slot_end = half_end && hi;
  assign mdc      = hi;

  AST_MDC_HALF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(half_end) |-> $stable(mdc)); // R2
endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_rd,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              slot_end,
  input  logic              din,
  output logic              run,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data
);
  phase_t            ph;
  logic [IDX_W-1:0]  idx;
  logic              is_rd;
  logic [HDR_W-1:0]  hdr_sr;
  logic [DATA_W-1:0] wsr;
  logic [DATA_W-1:0] acc;

  // named internal events
  logic accept, last_slot, ta_bad, frame_end;

  assign accept = req && (ph == PH_IDLE);

  always_comb begin
    unique case (ph)
      PH_PRE:   last_slot = (idx == IDX_W'(PRE_SLOTS - 1));
      PH_HDR:   last_slot = (idx == IDX_W'(HDR_W - 1));
      PH_TA:    last_slot = (idx == IDX_W'(ta_slots(is_rd) - 1));
      PH_WDAT,
      PH_RDAT:  last_slot = (idx == IDX_W'(DATA_W - 1));
      PH_TAIL:  last_slot = (idx == IDX_W'(tail_slots(is_rd) - 1));
      PH_FLUSH: last_slot = (idx == IDX_W'(FLUSH_SLOTS - 1));
      default:  last_slot = 1'b0;
    endcase
  end

  assign ta_bad    = slot_end && (ph == PH_TA) && is_rd && din;
  assign frame_end = slot_end && last_slot && ((ph == PH_TAIL) || (ph == PH_FLUSH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      idx     <= '0;
      is_rd   <= 1'b0;
      hdr_sr  <= '0;
      wsr     <= '0;
      acc     <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        ph     <= PH_PRE;
        idx    <= '0;
        is_rd  <= req_rd;
        hdr_sr <= make_header(req_rd, req_phy, req_reg);
        wsr    <= req_wdata;
        acc    <= '0;
      end else if (slot_end) begin
        idx <= last_slot ? '0 : idx + 1'b1;
        unique case (ph)
          PH_PRE: if (last_slot) ph <= PH_HDR;
          PH_HDR: begin
            hdr_sr <= hdr_sr << 1;
            if (last_slot) ph <= PH_TA;
          end
          PH_TA: begin
            if (is_rd)          ph <= ta_bad ? PH_FLUSH : PH_RDAT;
            else if (last_slot) ph <= PH_WDAT;
          end
          PH_WDAT: begin
            wsr <= wsr << 1;
            if (last_slot) ph <= PH_TAIL;
          end
          PH_RDAT: begin
            acc <= {acc[DATA_W-2:0], din};
            if (last_slot) ph <= PH_TAIL;
          end
          PH_TAIL, PH_FLUSH: begin
            if (frame_end) begin
              ph   <= PH_IDLE;
              done <= 1'b1;
              err  <= (ph == PH_FLUSH);
              if (is_rd) rd_data <= (ph == PH_FLUSH) ? '0 : acc;
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  assign run = (ph != PH_IDLE);

  always_comb begin
    mdio_oe = 1'b0;
    mdio_o  = 1'b0;
    unique case (ph)
      PH_PRE:  begin mdio_oe = 1'b1; mdio_o = 1'b1; end
      PH_HDR:  begin mdio_oe = 1'b1; mdio_o = hdr_sr[HDR_W-1]; end
      PH_TA:   begin mdio_oe = !is_rd; mdio_o = !is_rd && (idx == '0); end
      PH_WDAT: begin mdio_oe = 1'b1; mdio_o = wsr[DATA_W-1]; end
      default: begin mdio_oe = 1'b0; mdio_o = 1'b0; end
    endcase
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> done); // R9
  AST_ERR_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> is_rd); // R8
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && ((ph == PH_RDAT) || (ph == PH_TAIL) || (ph == PH_FLUSH))) |-> !mdio_oe); // R6
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req && run) |=> $stable(is_rd)); // R10
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_rd,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic run, half_end, slot_end, din;

  mdc_phase_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .mdc(mdc), .half_end(half_end), .slot_end(slot_end)
  );

  mdio_in_sync u_sync (
    .clk(clk), .rst_n(rst_n), .d(mdio_i), .q(din)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .req(req), .req_rd(req_rd), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .slot_end(slot_end), .din(din),
    .run(run), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .err(err), .rd_data(rd_data)
  );

  assign busy = run;

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R2
  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R6
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_rd = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, err, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i = 1'b1;

  always #4 clk = ~clk;

  mdio_mgmt_master #(.HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0, n_fail = 0;
  int tick = 0, last_rise = 0, rise_cnt = 0, drv_cnt = 0, half_bad = 0;
  logic [63:0] drv_bits = '0;
  logic [4:0] model_phy = 5'h0A;
  logic [15:0] salt = 16'h3C5A;
  bit rsp_active = 0;
  logic [15:0] rsp_data = '0;
  logic [15:0] exp_rd = '0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] phy_value(input logic [4:0] p, input logic [4:0] r);
    return salt ^ {p, r, p ^ r, 1'b1};
  endfunction

  function automatic logic [63:0] push(input logic [63:0] v, input logic b);
    return {v[62:0], b};
  endfunction

  // expected driven bit stream, newest bit at LSB
  function automatic logic [63:0] exp_stream(input bit rd, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [63:0] v = '0;
    for (int i = 0; i < 32; i++) v = push(v, 1'b1);
    v = push(v, 1'b0); v = push(v, 1'b1);
    v = push(v, rd ? 1'b1 : 1'b0); v = push(v, rd ? 1'b0 : 1'b1);
    for (int i = 4; i >= 0; i--) v = push(v, p[i]);
    for (int i = 4; i >= 0; i--) v = push(v, r[i]);
    if (!rd) begin
      v = push(v, 1'b1); v = push(v, 1'b0);
      for (int i = 15; i >= 0; i--) v = push(v, d[i]);
    end
    return v;
  endfunction

  always @(posedge clk) tick++;

  always @(posedge mdc) begin
    if (rise_cnt > 0 && (tick - last_rise) != 2 * H) half_bad++;
    last_rise = tick;
    if (mdio_oe) begin
      drv_cnt++;
      drv_bits = push(drv_bits, mdio_o);
    end
    rise_cnt++;
  end

  // bench PHY: decodes header on its own, answers reads to model_phy
  always @(negedge mdc) begin
    if ((tick - last_rise) != H) half_bad++;
    if (rise_cnt == 46) begin
      rsp_active = (drv_bits[11:10] == 2'b10) && (drv_bits[9:5] == model_phy);
      rsp_data   = phy_value(drv_bits[9:5], drv_bits[4:0]);
      mdio_i     = rsp_active ? 1'b0 : 1'b1;
    end else if (rise_cnt >= 47 && rise_cnt <= 62 && rsp_active) begin
      mdio_i = rsp_data[62 - rise_cnt];
    end else begin
      mdio_i = 1'b1;
    end
  end

  task automatic run_txn(input bit rd, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input bit inject);
    int cyc = 0;
    int n_slots;
    int dones = 0;
    bit present;
    logic [63:0] exp;
    string tg;
    rise_cnt = 0; drv_cnt = 0; drv_bits = '0; half_bad = 0; rsp_active = 0;
    present = rd && (p == model_phy);
    n_slots = (rd && !present) ? 79 : 65;
    @(negedge clk);
    req = 1'b1; req_rd = rd; req_phy = p; req_reg = r; req_wdata = d;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        req = 1'b0;
        check(busy === 1'b1, "R9 busy after accept", busy, 1);
      end
      if (inject && cyc == 40) begin
        req = 1'b1; req_rd = !rd; req_phy = ~p; req_reg = ~r; req_wdata = ~d;
      end
      if (inject && cyc == 41) req = 1'b0;
      if (done) dones++;
    end while (!done && cyc < 2 * H * 79 + 40);
    check(done === 1'b1, "R9 done reached (watchdog)", done, 1);
    check(cyc == 2 * H * n_slots + 1, "R9 done latency", cyc, 2 * H * n_slots + 1);
    check(busy === 1'b0, "R9 busy low at done", busy, 0);
    check(rise_cnt == n_slots, rd ? (present ? "R7 mdc count" : "R8 mdc count") : "R5 mdc count",
          rise_cnt, n_slots);
    check(drv_cnt == (rd ? 46 : 64), rd ? "R6 driven cycles" : "R5 driven cycles", drv_cnt, rd ? 46 : 64);
    check(half_bad == 0, "R2 mdc half width", half_bad, 0);
    exp = exp_stream(rd, p, r, d);
    if (rd) begin
      check(drv_bits[45:14] == 32'hFFFF_FFFF, "R3 preamble", drv_bits[45:14], 32'hFFFF_FFFF);
      check(drv_bits[13:0] == exp[13:0], "R4 header", drv_bits[13:0], exp[13:0]);
      if (present) exp_rd = phy_value(p, r); else exp_rd = '0;
      tg = present ? "R7 read data/err" : "R8 error read";
      check(err === !present, tg, err, !present);
      check(rd_data === exp_rd, tg, rd_data, exp_rd);
    end else begin
      check(drv_bits[63:32] == 32'hFFFF_FFFF, "R3 preamble", drv_bits[63:32], 32'hFFFF_FFFF);
      check(drv_bits[31:18] == exp[31:18], "R4 header", drv_bits[31:18], exp[31:18]);
      check(drv_bits[17:0] == exp[17:0], "R5 turnaround+data", drv_bits[17:0], exp[17:0]);
      check(err === 1'b0, "R5 write err", err, 0);
      check(rd_data === exp_rd, "R5 rd_data kept", rd_data, exp_rd);
    end
    @(negedge clk);
    check(done === 1'b0, "R9 done single cycle", done, 0);
    for (int i = 0; i < 6 * H; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(rise_cnt == n_slots && busy === 1'b0 && dones == 1,
          inject ? "R10 busy request ignored" : "R10 no extra frame", rise_cnt, n_slots);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check(busy === 0 && done === 0 && err === 0 && mdc === 0 && mdio_oe === 0 && rd_data === 0,
          "R1 reset state", {busy, done, err, mdc, mdio_oe, rd_data}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mdc === 0 && busy === 0, "R1 idle after reset", {mdc, busy}, 0);

    run_txn(0, 5'h00, 5'h00, 16'h0000, 0);
    run_txn(0, 5'h1F, 5'h1F, 16'hFFFF, 0);
    run_txn(1, model_phy, 5'h02, 16'h0, 0);
    run_txn(1, 5'h1F, 5'h02, 16'h0, 0);
    run_txn(0, 5'h11, 5'h0E, 16'h8001, 0);
    salt = 16'hFFFE;
    run_txn(1, model_phy, 5'h00, 16'h0, 0);
    run_txn(1, model_phy, 5'h1F, 16'h0, 1);
    run_txn(0, 5'h05, 5'h0A, 16'h5AA5, 1);
    run_txn(1, 5'h00, 5'h00, 16'h0, 1);
    for (int k = 0; k < 24; k++) begin
      bit rd;
      logic [4:0] p, r;
      rd = $urandom_range(0, 1);
      p = ($urandom_range(0, 3) != 0) ? model_phy : 5'($urandom);
      r = 5'($urandom);
      salt = 16'($urandom);
      run_txn(rd, p, r, 16'($urandom), ($urandom_range(0, 4) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule